// File: doc/BRIEF.md
# Masked Interrupt Register Group

This block is a small memory-mapped interrupt register slice with four 32-bit word registers: a pending-status register, a mask register, and two write-only alias registers that clear or set mask bits. It sits behind a plain register bus with address, write strobe, write data and combinational read data. It drives one level-sensitive interrupt line.

Hardware event inputs latch pending bits in the status register. Software acknowledges an event by writing a one to the matching status bit. The mask register cannot be written directly. Software changes it through the unmask alias, where each written one clears the matching mask bit, or through the setmask alias, where each written one sets it. After reset every source is masked.

The number of sources is a parameter (`N_SRC`, default 1). Register word offsets are: status 0x00, mask 0x04, unmask 0x08, setmask 0x0C. The bus carries aligned 32-bit little-endian words.

Top module: `irq_mask_regs`

## Requirements
- R1: After reset the status register reads 0, the mask register reads all ones in its low `N_SRC` bits (0x1 by default), and `irq_o` is low.
- R2: A write to status (offset 0x00) clears each status bit written as 1 and leaves each bit written as 0 unchanged; the clear takes effect at the clock edge of the write.
- R3: A high `event_i[i]` at a clock edge sets status bit i; if a clear of that bit arrives on the same edge, the bit ends set.
- R4: Writes to the mask register (offset 0x04) change nothing; it reads back the current mask.
- R5: A write to unmask (offset 0x08) clears every mask bit whose data bit is 1 and keeps the others.
- R6: A write to setmask (offset 0x0C) sets every mask bit whose data bit is 1 and keeps the others.
- R7: Reads of the unmask and setmask offsets always return 0.
- R8: `irq_o` is high exactly when some status bit is 1 while its mask bit is 0, and it follows register changes with no extra cycle of delay.
- R9: Accesses to an offset other than the four listed ones, including an address with nonzero bits [1:0], read as 0, and writes to such an address are ignored.
- R10: Data bits at and above `N_SRC` are ignored on writes and read as 0 in status and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| event_i | input | N_SRC | Hardware event inputs, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an event and a software acknowledge of the same bit landing on one clock edge. Only that case shows which of the two has priority. The stimulus raises `event_i` and a status write of ones within the same cycle window, then reads status back. Misaligned addresses that alias a valid word offset are also driven. This confirms that a write with the unmask offset and nonzero low address bits leaves the mask untouched.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_REGS = 4;

  // word index in the register window
  typedef enum logic [1:0] {
    REG_STAT    = 2'd0,
    REG_MASK    = 2'd1,
    REG_UNMASK  = 2'd2,
    REG_SETMASK = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic stat;
    logic mask;
    logic unmask;
    logic setmask;
  } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_o = '0;
    if (aligned) begin
      sel_o.stat    = (word == WORD_W'(REG_STAT));
      sel_o.mask    = (word == WORD_W'(REG_MASK));
      sel_o.unmask  = (word == WORD_W'(REG_UNMASK));
      sel_o.setmask = (word == WORD_W'(REG_SETMASK));
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N_SRC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] event_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_data_i,
  output logic [N_SRC-1:0] status_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic clr;
    assign clr = clr_we_i & clr_data_i[i];

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         status_o[i] <= 1'b0;
      else if (event_i[i]) status_o[i] <= 1'b1;
      else if (clr)        status_o[i] <= 1'b0;
    end

    p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[i] |=> status_o[i]);
    p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_data_i[i] && !event_i[i]) |=> !status_o[i]);
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_i[i] && !(clr_we_i && clr_data_i[i])) |=> $stable(status_o[i]));
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N_SRC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unmask_we_i,
  input  logic             setmask_we_i,
  input  logic [N_SRC-1:0] data_i,
  output logic [N_SRC-1:0] mask_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mask_o[i] <= 1'b1;
      else if (setmask_we_i && data_i[i]) mask_o[i] <= 1'b1;
      else if (unmask_we_i && data_i[i])  mask_o[i] <= 1'b0;
    end

    p_unmask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unmask_we_i && !setmask_we_i && data_i[i]) |=> !mask_o[i]);
    p_setmask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (setmask_we_i && data_i[i]) |=> mask_o[i]);
    p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((unmask_we_i || setmask_we_i) && data_i[i]) |=> $stable(mask_o[i]));
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned N_SRC  = 1,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_SRC-1:0]  event_i,
  output logic              irq_o
);
  localparam int unsigned SRC_W = N_SRC;

  reg_sel_t          sel;
  logic [SRC_W-1:0]  status;
  logic [SRC_W-1:0]  mask;
  logic [SRC_W-1:0]  wbits;
  logic              unused_wdata;

  assign wbits        = wdata_i[SRC_W-1:0];
  assign unused_wdata = ^wdata_i;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  irq_status_bank #(.N_SRC(SRC_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .clr_we_i   (we_i & sel.stat),
    .clr_data_i (wbits),
    .status_o   (status)
  );

  irq_mask_bank #(.N_SRC(SRC_W)) u_mask (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .unmask_we_i  (we_i & sel.unmask),
    .setmask_we_i (we_i & sel.setmask),
    .data_i       (wbits),
    .mask_o       (mask)
  );

  assign irq_o = |(status & ~mask);

  always_comb begin
    rdata_o = '0;
    if (sel.stat)      rdata_o = DATA_W'(status);
    else if (sel.mask) rdata_o = DATA_W'(mask);
  end

  p_sel_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  p_alias_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel.unmask || sel.setmask) |-> (rdata_o == '0));
  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> !irq_o);
  p_reset_masked_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (&mask) && !irq_o);
endmodule

// File: tb/irq_mask_regs_test.sv
`timescale 1ns/100ps
module irq_mask_regs_test;
  localparam int unsigned N_SRC  = 1;
  localparam int unsigned ADDR_W = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [N_SRC-1:0]  event_i = '0;
  logic              irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  logic m_stat = 1'b0;
  logic m_mask = 1'b1;

  always #2.5 clk_i = ~clk_i;

  irq_mask_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .event_i(event_i), .irq_o(irq_o)
  );

  // model of read data for an address
  function automatic logic [31:0] model_rd(input logic [ADDR_W-1:0] a);
    if (a == 6'h00) return {31'd0, m_stat};
    if (a == 6'h04) return {31'd0, m_mask};
    return 32'd0;
  endfunction

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    @(posedge clk_i); #1;
    addr_i = a; we_i = 1'b0;
    exp_q.push_back({m_stat & ~m_mask, model_rd(a)});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic ev);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; we_i = 1'b1; event_i = ev;
    @(posedge clk_i); #1;
    we_i = 1'b0; event_i = '0;
    if (ev) m_stat = 1'b1;
    else if (a == 6'h00 && d[0]) m_stat = 1'b0;
    if (a == 6'h08 && d[0]) m_mask = 1'b0;
    if (a == 6'h0C && d[0]) m_mask = 1'b1;
  endtask

  task automatic pulse_event();
    @(posedge clk_i); #1;
    event_i = 1'b1;
    @(posedge clk_i); #1;
    event_i = '0;
    m_stat = 1'b1;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata_o !== e[31:0] || irq_o !== e[32]) begin
        bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 t, rdata_o, irq_o, e[31:0], e[32]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    rd(6'h00, "R1 status after reset");
    rd(6'h04, "R1 mask after reset");
    // R3: event sets status, masked so no irq
    pulse_event();
    rd(6'h00, "R3 event sets status");
    // R4: direct mask write ignored
    wr(6'h04, 32'h0, 1'b0);
    rd(6'h04, "R4 mask write ignored");
    // R5: unmask
    wr(6'h08, 32'h1, 1'b0);
    rd(6'h04, "R5 unmask clears mask, R8 irq high");
    // R7
    rd(6'h08, "R7 unmask reads zero");
    rd(6'h0C, "R7 setmask reads zero");
    // R2
    wr(6'h00, 32'h0, 1'b0);
    rd(6'h00, "R2 write zero keeps status");
    wr(6'h00, 32'h1, 1'b0);
    rd(6'h00, "R2 write one clears status, R8 irq low");
    // R3 set wins over same-cycle clear
    wr(6'h00, 32'h1, 1'b1);
    rd(6'h00, "R3 set wins over clear");
    // R6
    wr(6'h0C, 32'h0, 1'b0);
    rd(6'h04, "R6 setmask zero keeps mask");
    wr(6'h0C, 32'h1, 1'b0);
    rd(6'h04, "R6 setmask sets mask, irq low");
    rd(6'h00, "R8 masked pending no irq");
    // R9 unused and misaligned
    wr(6'h10, 32'hFFFF_FFFF, 1'b0);
    rd(6'h10, "R9 unused offset reads zero");
    rd(6'h04, "R9 unused write no effect on mask");
    wr(6'h09, 32'h1, 1'b0);
    rd(6'h04, "R9 misaligned unmask ignored");
    wr(6'h02, 32'h1, 1'b0);
    rd(6'h00, "R9 misaligned status clear ignored");
    rd(6'h05, "R9 misaligned read zero");
    // R10 upper bits
    wr(6'h08, 32'hFFFF_FFFE, 1'b0);
    rd(6'h04, "R10 upper unmask bits ignored");
    wr(6'h00, 32'hFFFF_FFFE, 1'b0);
    rd(6'h00, "R10 upper status bits ignored");
    // R8 irq follows status with mask clear
    wr(6'h08, 32'h1, 1'b0);
    rd(6'h00, "R8 pending unmasked raises irq");
    wr(6'h00, 32'h1, 1'b0);
    rd(6'h00, "R8 cleared drops irq");
    pulse_event();
    rd(6'h04, "R8 event raises irq at once");
    repeat (3) @(posedge clk_i);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule